// File: doc/BRIEF.md
# Core Mailbox and Signal Notification Unit

This unit carries short messages between one compute core and the agents outside it. Outside agents write 32-bit words into an inbound queue of four entries. The core drains this queue through a blocking channel read. In the other direction, the core posts words into two single-entry outbound mailboxes through a blocking channel write, and outside agents collect them with memory-mapped reads. Posting to the second outbound mailbox raises a level interrupt toward the host. That interrupt holds until the host has collected the word.

Two signal-notification registers let many senders notify the core. Each register has its own mode. In overwrite mode the newest host write replaces the contents. In accumulate mode each write is ORed into the contents, so bit flags from several senders combine. A core read returns the contents and clears them. A register that holds zero has nothing pending.

The core sees a count for every channel, and it can read these counts at any time without blocking. The inbound queue reports how many words it holds. Each outbound mailbox reports one free slot or none. Each signal register reports one pending value or none.

The inbound queue is controlled by a state machine with three states: IB_EMPTY, IB_PART and IB_FULL. A push from IB_EMPTY moves it to IB_PART. It moves to IB_FULL when the count reaches the depth, and back to IB_PART or IB_EMPTY as pops lower the count. A push without a pop while in IB_FULL stays in IB_FULL.

Each outbound mailbox is controlled by a state machine with two states: OB_EMPTY and OB_FULL. A core write moves OB_EMPTY to OB_FULL. A host read moves OB_FULL back to OB_EMPTY.

Top module: `msg_channel_hub`

## Requirements
- R1: After reset, the following hold:
  - `inbox_count` is 0.
  - `outbox_space` is 2'b11.
  - `sig_pending` is 0.
  - `host_irq` is low.
  - `inbox_overflow` is low.
- R2: A host write with `host_addr`=0 pushes a word into the inbound queue. The core reads words back in the order they were written, using `core_rd_chan`=0. `inbox_count` tracks the number held, up to 4.
- R3: A core read of an empty inbound queue gets no `core_rd_ack`. A push in that same cycle does not bypass to the core. The read is acknowledged, with the pushed word, in the cycle after that push.
- R4: A host push into a full queue without a same-cycle pop overwrites the newest entry. The count stays at 4, and `inbox_overflow` becomes set and stays set until reset.
- R5: A core pop and a host push in the same cycle on a full queue both take effect. No overflow is flagged and the order is kept.
- R6: A core write (`core_wr_chan`: 0 = mailbox 0, 1 = mailbox 1) is acknowledged only when the target mailbox is empty.
  - While the mailbox is full, the write waits.
  - A host read (`host_addr` 1 = mailbox 0, 2 = mailbox 1) returns the stored word and frees the mailbox.
  - A blocked write succeeds in the following cycle.
  - `host_rd_data` is 0 for an empty mailbox.
- R7: `host_irq` rises in the cycle after a core write into mailbox 1. It holds until the host reads address 2. Writes into mailbox 0 never raise it.
- R8: A signal register whose `sig_or_mode` bit is 0 takes the value of each host write (`host_addr` 3 = signal 0, 4 = signal 1). Writing zero leaves nothing pending.
- R9: A signal register whose `sig_or_mode` bit is 1 ORs each host write into its contents.
- R10: A core read of a signal register returns its contents and clears it to zero. Reading signal 0 uses `core_rd_chan`=1 and signal 1 uses 2. A signal register holding zero gives no `core_rd_ack`.
- R11: When a core read and a host write hit the same signal register in one cycle, the read returns the old contents. The register then holds exactly the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_rd_req | input | 1 | Core channel read request, held until acknowledged |
| core_rd_chan | input | 2 | Read channel: 0 inbox, 1 signal 0, 2 signal 1 |
| core_rd_ack | output | 1 | Read completes this cycle |
| core_rd_data | output | DATA_W | Word returned with the acknowledge |
| core_wr_req | input | 1 | Core channel write request, held until acknowledged |
| core_wr_chan | input | 1 | Write channel: 0 mailbox 0, 1 mailbox 1 |
| core_wr_data | input | DATA_W | Word to post |
| core_wr_ack | output | 1 | Write accepted this cycle |
| inbox_count | output | CW | Words held in the inbound queue |
| outbox_space | output | 2 | Free slot per outbound mailbox |
| sig_pending | output | 2 | Pending value per signal register |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe (collects a mailbox) |
| host_addr | input | 3 | Host register select |
| host_wr_data | input | DATA_W | Host write word |
| host_rd_data | output | DATA_W | Word of the addressed mailbox, 0 if empty |
| sig_or_mode | input | 2 | Per signal register: 1 accumulate, 0 overwrite |
| inbox_overflow | output | 1 | Sticky inbound overflow flag |
| host_irq | output | 1 | Level interrupt while mailbox 1 is full |

## Verification
Two kinds of access can land in the same cycle.

The first is a core pop and a host push on the inbound queue. The bench fills the queue, then raises a core read and a host write to address 0 on one edge. It requires the oldest word to come back, the count to remain 4, the overflow flag to stay clear, and the remaining order to be intact. The same overlap is also driven on an empty queue, where the acknowledge must wait one cycle.

The second is a core read and a host write on one signal register in accumulate mode. The bench requires the read to return the old contents. The register must then hold only the newly written word.

// File: rtl/msg_hub_pkg.sv
package msg_hub_pkg;

    typedef enum logic [1:0] {
        RDCH_INBOX = 2'd0,
        RDCH_SIG0  = 2'd1,
        RDCH_SIG1  = 2'd2,
        RDCH_NONE  = 2'd3
    } rd_chan_e;

    typedef enum logic [1:0] {
        IB_EMPTY = 2'd0,
        IB_PART  = 2'd1,
        IB_FULL  = 2'd2
    } ib_state_e;

    typedef enum logic {
        OB_EMPTY = 1'b0,
        OB_FULL  = 1'b1
    } ob_state_e;

    localparam logic [2:0] HA_INBOX = 3'd0;
    localparam logic [2:0] HA_OUT0  = 3'd1;
    localparam logic [2:0] HA_SIG0  = 3'd3;

endpackage

// File: rtl/msg_inbox_fifo.sv
module msg_inbox_fifo
    import msg_hub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              ovf
);

    ib_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [AW-1:0]     wr_ptr, rd_ptr, wr_addr;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              ovf_q;
    logic              do_pop, overwrite;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_prev(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
    endfunction

    // next-state and count
    always_comb begin
        do_pop    = pop && (state_q != IB_EMPTY);
        overwrite = push && !do_pop && (state_q == IB_FULL);
        cnt_d     = cnt_q;
        unique case (state_q)
            IB_EMPTY: if (push) cnt_d = CW'(1);
            IB_PART:  cnt_d = cnt_q + CW'(push) - CW'(do_pop);
            IB_FULL:  if (do_pop && !push) cnt_d = cnt_q - 1'b1;
            default:  cnt_d = '0;
        endcase
        if (cnt_d == '0)               state_d = IB_EMPTY;
        else if (cnt_d == CW'(DEPTH))  state_d = IB_FULL;
        else                           state_d = IB_PART;
        wr_addr = overwrite ? ptr_prev(wr_ptr) : wr_ptr;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IB_EMPTY;
            cnt_q   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (push && !overwrite) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)             rd_ptr <= ptr_next(rd_ptr);
            if (overwrite)          ovf_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_addr] <= push_data;
    end

    // outputs
    always_comb begin
        head  = mem[rd_ptr];
        count = cnt_q;
        ovf   = ovf_q;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_empty_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IB_EMPTY) == (cnt_q == '0));
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IB_FULL && push && !pop) |=> (state_q == IB_FULL && ovf_q));
    assert_swap_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IB_FULL && push && pop && !ovf_q) |=> (!ovf_q && state_q == IB_FULL));

endmodule

// File: rtl/msg_outbox_slot.sv
module msg_outbox_slot
    import msg_hub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit IRQ_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              irq
);

    ob_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OB_EMPTY: if (wr) state_d = OB_FULL;
            OB_FULL:  if (rd) state_d = OB_EMPTY;
            default:  state_d = OB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OB_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr && state_q == OB_EMPTY) data_q <= wr_data;
        end
    end

    always_comb begin
        full = (state_q == OB_FULL);
        data = data_q;
        irq  = IRQ_EN && (state_q == OB_FULL);
    end

    assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OB_EMPTY && wr) |=> (full && data == $past(wr_data)));
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd) |=> (full && $stable(data)));
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd) |=> irq);

endmodule

// File: rtl/msg_sig_reg.sv
module msg_sig_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              or_mode,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    output logic [DATA_W-1:0] value,
    output logic              pending
);

    logic [DATA_W-1:0] val_q, val_d, base;

    always_comb begin
        base  = rd ? '0 : val_q;
        val_d = base;
        if (wr) val_d = or_mode ? (base | wr_data) : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    always_comb begin
        value   = val_q;
        pending = (val_q != '0);
    end

    assert_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !or_mode) |=> (value == $past(wr_data)));
    assert_accumulate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && or_mode && !rd) |=> (value == ($past(value) | $past(wr_data))));
    assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> !pending);
    assert_read_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |=> (value == $past(wr_data)));

endmodule

// File: rtl/msg_channel_hub.sv
module msg_channel_hub
    import msg_hub_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IB_DEPTH = 4,
    localparam int CW      = $clog2(IB_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_rd_req,
    input  logic [1:0]        core_rd_chan,
    output logic              core_rd_ack,
    output logic [DATA_W-1:0] core_rd_data,
    input  logic              core_wr_req,
    input  logic              core_wr_chan,
    input  logic [DATA_W-1:0] core_wr_data,
    output logic              core_wr_ack,
    output logic [CW-1:0]     inbox_count,
    output logic [1:0]        outbox_space,
    output logic [1:0]        sig_pending,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic [1:0]        sig_or_mode,
    output logic              inbox_overflow,
    output logic              host_irq
);

    localparam int NCH = 2;

    logic              ib_push, ib_pop;
    logic [DATA_W-1:0] ib_head;
    logic [CW-1:0]     ib_cnt;
    logic              ib_ovf;

    logic [NCH-1:0]    ob_wr, ob_rd, ob_full, ob_irq;
    logic [DATA_W-1:0] ob_data [NCH];
    logic [NCH-1:0]    sg_wr, sg_rd, sg_pend;
    logic [DATA_W-1:0] sg_val [NCH];

    assign ib_push = host_wr_en && (host_addr == HA_INBOX);

    msg_inbox_fifo #(.DATA_W(DATA_W), .DEPTH(IB_DEPTH)) u_inbox (
        .clk(clk), .rst_n(rst_n),
        .push(ib_push), .push_data(host_wr_data),
        .pop(ib_pop), .head(ib_head), .count(ib_cnt), .ovf(ib_ovf)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ob_rd[g] = host_rd_en && (host_addr == 3'(HA_OUT0 + g));
        assign ob_wr[g] = core_wr_ack && (core_wr_chan == 1'(g));
        assign sg_wr[g] = host_wr_en && (host_addr == 3'(HA_SIG0 + g));
        assign sg_rd[g] = core_rd_ack && (core_rd_chan == 2'(RDCH_SIG0 + g));

        msg_outbox_slot #(.DATA_W(DATA_W), .IRQ_EN(g == NCH - 1)) u_outbox (
            .clk(clk), .rst_n(rst_n),
            .wr(ob_wr[g]), .wr_data(core_wr_data), .rd(ob_rd[g]),
            .full(ob_full[g]), .data(ob_data[g]), .irq(ob_irq[g])
        );

        msg_sig_reg #(.DATA_W(DATA_W)) u_sig (
            .clk(clk), .rst_n(rst_n), .or_mode(sig_or_mode[g]),
            .wr(sg_wr[g]), .wr_data(host_wr_data), .rd(sg_rd[g]),
            .value(sg_val[g]), .pending(sg_pend[g])
        );
    end

    // core read channel: acknowledge only when the selected channel holds data
    always_comb begin
        core_rd_ack  = 1'b0;
        core_rd_data = '0;
        unique case (core_rd_chan)
            RDCH_INBOX: begin
                core_rd_ack  = core_rd_req && (ib_cnt != '0);
                core_rd_data = ib_head;
            end
            RDCH_SIG0: begin
                core_rd_ack  = core_rd_req && sg_pend[0];
                core_rd_data = sg_val[0];
            end
            RDCH_SIG1: begin
                core_rd_ack  = core_rd_req && sg_pend[1];
                core_rd_data = sg_val[1];
            end
            default: begin
                core_rd_ack  = 1'b0;
                core_rd_data = '0;
            end
        endcase
    end

    assign ib_pop      = core_rd_ack && (core_rd_chan == RDCH_INBOX);
    assign core_wr_ack = core_wr_req && !ob_full[core_wr_chan];

    // host side read mux
    always_comb begin
        host_rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (host_addr == 3'(HA_OUT0 + i) && ob_full[i]) host_rd_data = ob_data[i];
        end
    end

    assign inbox_count    = ib_cnt;
    assign outbox_space   = ~ob_full;
    assign sig_pending    = sg_pend;
    assign inbox_overflow = ib_ovf;
    assign host_irq       = |ob_irq;

    assert_rd_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_req && core_rd_chan == RDCH_INBOX && inbox_count == '0) |-> !core_rd_ack);
    assert_wr_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_req && !outbox_space[core_wr_chan]) |-> !core_wr_ack);
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(core_wr_ack && core_wr_chan));
    assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && host_rd_en && host_addr == 3'd2) |=> !host_irq);
    assert_sig_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_req && core_rd_chan != RDCH_INBOX && core_rd_chan != RDCH_NONE
         && !sig_pending[core_rd_chan[1]]) |-> !core_rd_ack);

endmodule

// File: tb/msg_channel_hub_tb.sv
module msg_channel_hub_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_rd_req = 1'b0;
    logic [1:0]    core_rd_chan = 2'd0;
    logic          core_rd_ack;
    logic [DW-1:0] core_rd_data;
    logic          core_wr_req = 1'b0;
    logic          core_wr_chan = 1'b0;
    logic [DW-1:0] core_wr_data = '0;
    logic          core_wr_ack;
    logic [2:0]    inbox_count;
    logic [1:0]    outbox_space;
    logic [1:0]    sig_pending;
    logic          host_wr_en = 1'b0;
    logic          host_rd_en = 1'b0;
    logic [2:0]    host_addr = 3'd0;
    logic [DW-1:0] host_wr_data = '0;
    logic [DW-1:0] host_rd_data;
    logic [1:0]    sig_or_mode = 2'b10;
    logic          inbox_overflow;
    logic          host_irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    msg_channel_hub u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_rd_req(core_rd_req), .core_rd_chan(core_rd_chan),
        .core_rd_ack(core_rd_ack), .core_rd_data(core_rd_data),
        .core_wr_req(core_wr_req), .core_wr_chan(core_wr_chan),
        .core_wr_data(core_wr_data), .core_wr_ack(core_wr_ack),
        .inbox_count(inbox_count), .outbox_space(outbox_space),
        .sig_pending(sig_pending),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
        .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
        .sig_or_mode(sig_or_mode), .inbox_overflow(inbox_overflow), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [DW-1:0] d);
        host_wr_en = 1'b1; host_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
        host_rd_en = 1'b1; host_addr = a;
        #1 chk(tag, host_rd_data, exp);
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic core_rd(input logic [1:0] ch, input logic [DW-1:0] exp, input string tag);
        core_rd_req = 1'b1; core_rd_chan = ch;
        #1 chk({tag, " ack"}, DW'(core_rd_ack), 1);
        chk(tag, core_rd_data, exp);
        @(negedge clk);
        core_rd_req = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 inbox_count", DW'(inbox_count), 0);
        chk("R1 outbox_space", DW'(outbox_space), 3);
        chk("R1 sig_pending", DW'(sig_pending), 0);
        chk("R1 irq", DW'(host_irq), 0);
        chk("R1 overflow", DW'(inbox_overflow), 0);
    endtask

    task automatic t_fifo_order;
        for (int i = 0; i < 4; i++) host_wr(3'd0, DW'(32'h100 + i));
        chk("R2 count full", DW'(inbox_count), 4);
        for (int i = 0; i < 4; i++) core_rd(2'd0, DW'(32'h100 + i), "R2 order");
        chk("R2 count drained", DW'(inbox_count), 0);
    endtask

    task automatic t_block;
        core_rd_req = 1'b1; core_rd_chan = 2'd0;
        #1 chk("R3 empty no ack", DW'(core_rd_ack), 0);
        host_wr_en = 1'b1; host_addr = 3'd0; host_wr_data = 32'hB10C;
        #1 chk("R3 no bypass", DW'(core_rd_ack), 0);
        @(negedge clk);
        host_wr_en = 1'b0;
        #1 chk("R3 ack after push", DW'(core_rd_ack), 1);
        chk("R3 data", core_rd_data, 32'hB10C);
        @(negedge clk);
        core_rd_req = 1'b0;
        chk("R3 count", DW'(inbox_count), 0);
    endtask

    task automatic t_simul;
        for (int i = 1; i <= 4; i++) host_wr(3'd0, DW'(32'h11 * i));
        core_rd_req = 1'b1; core_rd_chan = 2'd0;
        host_wr_en = 1'b1; host_addr = 3'd0; host_wr_data = 32'h55;
        #1 chk("R5 pop oldest", core_rd_data, 32'h11);
        @(negedge clk);
        core_rd_req = 1'b0; host_wr_en = 1'b0;
        chk("R5 count", DW'(inbox_count), 4);
        chk("R5 no overflow", DW'(inbox_overflow), 0);
        core_rd(2'd0, 32'h22, "R5 order");
        core_rd(2'd0, 32'h33, "R5 order");
        core_rd(2'd0, 32'h44, "R5 order");
        core_rd(2'd0, 32'h55, "R5 order");
    endtask

    task automatic t_overflow;
        for (int i = 1; i <= 5; i++) host_wr(3'd0, DW'(32'hA0 + i));
        chk("R4 count", DW'(inbox_count), 4);
        chk("R4 overflow set", DW'(inbox_overflow), 1);
        core_rd(2'd0, 32'hA1, "R4 data");
        core_rd(2'd0, 32'hA2, "R4 data");
        core_rd(2'd0, 32'hA3, "R4 data");
        core_rd(2'd0, 32'hA5, "R4 newest replaced");
        chk("R4 overflow sticky", DW'(inbox_overflow), 1);
    endtask

    task automatic t_outbox;
        core_wr_req = 1'b1; core_wr_chan = 1'b0; core_wr_data = 32'hCAFE;
        #1 chk("R6 ack empty", DW'(core_wr_ack), 1);
        @(negedge clk);
        core_wr_req = 1'b0;
        chk("R6 space", DW'(outbox_space), 2'b10);
        chk("R7 no irq mbox0", DW'(host_irq), 0);
        core_wr_req = 1'b1; core_wr_data = 32'hBEEF;
        #1 chk("R6 blocked", DW'(core_wr_ack), 0);
        host_rd_en = 1'b1; host_addr = 3'd1;
        #1 chk("R6 host data", host_rd_data, 32'hCAFE);
        chk("R6 still blocked", DW'(core_wr_ack), 0);
        @(negedge clk);
        host_rd_en = 1'b0;
        #1 chk("R6 unblocked", DW'(core_wr_ack), 1);
        @(negedge clk);
        core_wr_req = 1'b0;
        host_rd(3'd1, 32'hBEEF, "R6 second word");
        host_addr = 3'd1;
        #1 chk("R6 empty reads 0", host_rd_data, 0);
        chk("R6 space back", DW'(outbox_space), 3);
    endtask

    task automatic t_irq;
        core_wr_req = 1'b1; core_wr_chan = 1'b1; core_wr_data = 32'h1234;
        #1 chk("R6 ack mbox1", DW'(core_wr_ack), 1);
        @(negedge clk);
        core_wr_req = 1'b0;
        chk("R7 irq raised", DW'(host_irq), 1);
        repeat (3) @(negedge clk);
        chk("R7 irq held", DW'(host_irq), 1);
        host_rd(3'd2, 32'h1234, "R7 mbox1 data");
        chk("R7 irq cleared", DW'(host_irq), 0);
    endtask

    task automatic t_sig_overwrite;
        sig_or_mode = 2'b10;
        host_wr(3'd3, 32'h5);
        host_wr(3'd3, 32'hA);
        chk("R8 pending", DW'(sig_pending), 2'b01);
        core_rd(2'd1, 32'hA, "R8 last write");
        chk("R10 cleared", DW'(sig_pending), 0);
        core_rd_req = 1'b1; core_rd_chan = 2'd1;
        #1 chk("R10 empty blocks", DW'(core_rd_ack), 0);
        @(negedge clk);
        core_rd_req = 1'b0;
        host_wr(3'd3, 32'h0);
        chk("R8 zero not pending", DW'(sig_pending), 0);
    endtask

    task automatic t_sig_or;
        host_wr(3'd4, 32'h1);
        host_wr(3'd4, 32'h4);
        core_rd(2'd2, 32'h5, "R9 accumulate");
        chk("R10 cleared sig1", DW'(sig_pending), 0);
    endtask

    task automatic t_sig_simul;
        host_wr(3'd4, 32'h3);
        core_rd_req = 1'b1; core_rd_chan = 2'd2;
        host_wr_en = 1'b1; host_addr = 3'd4; host_wr_data = 32'h10;
        #1 chk("R11 old value", core_rd_data, 32'h3);
        @(negedge clk);
        core_rd_req = 1'b0; host_wr_en = 1'b0;
        chk("R11 pending", DW'(sig_pending), 2'b10);
        core_rd(2'd2, 32'h10, "R11 new only");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fifo_order;
        t_block;
        t_simul;
        t_overflow;
        t_outbox;
        t_irq;
        t_sig_overwrite;
        t_sig_or;
        t_sig_simul;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule